// File: doc/BRIEF.md
# Main Road / Side Road Signal Controller

This block sequences the lamps at a junction where a busy main road meets a lightly used side road. A single sensor input reports whether a vehicle waits on the side road. With no such vehicle, the main road keeps its green forever. When a vehicle is reported, the main road passes through yellow to red and the side road gets its green. The side green is kept only while a vehicle is still sensed, and never past a long limit. The side road then passes through yellow back to red and the main road gets its green again. The main road always keeps its green for at least the long interval, even while side traffic waits.

An internal cycle-counting interval timer restarts on every phase change. It provides a short-interval flag, which times the yellow phases, and a long-interval flag, which times the green phases. Both intervals are parameters. The current phase and both timer flags are brought out for observation.

Top module: `road_signal_ctrl`

## Requirements
- R1: While `rst_n` is low, the phase code is 0 (main green), main lamps read green, side lamps read red, and both timer flags are low.
- R2: Phase codes are 0 main green, 1 main yellow, 2 side green, 3 side yellow. Each lamp vector is {red, yellow, green} in bits 2..0, so green=001, yellow=010, red=100. Phase 0 shows main 001 / side 100, phase 1 shows main 010 / side 100, phase 2 shows main 100 / side 001, and phase 3 shows main 100 / side 010.
- R3: In main green with no side vehicle sensed, the phase stays main green however long it lasts.
- R4: In main green with a vehicle sensed from the first cycle, main green lasts exactly LONG_CYC+1 cycles and is followed by main yellow.
- R5: When a vehicle first appears after main green's long interval has already expired, main yellow begins at the next clock edge.
- R6: Main yellow lasts exactly SHORT_CYC+1 cycles and is followed by side green.
- R7: In side green, a cycle with no vehicle sensed moves the controller to side yellow at the next clock edge.
- R8: In side green with a vehicle sensed throughout, side green lasts exactly LONG_CYC+1 cycles.
- R9: Side yellow lasts exactly SHORT_CYC+1 cycles, regardless of the sensor, and is followed by main green.
- R10: Both timer flags are low in the first cycle of every phase. The short flag first rises in the phase's cycle SHORT_CYC+1 and the long flag in cycle LONG_CYC+1. Each stays high until the phase ends, and the long flag is never high without the short flag.
- R11: In no cycle do both roads show a non-red lamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| car_i | input | 1 | Side-road vehicle present |
| phase_o | output | 2 | Current phase code |
| main_lamp_o | output | 3 | Main road lamps {red, yellow, green} |
| side_lamp_o | output | 3 | Side road lamps {red, yellow, green} |
| short_exp_o | output | 1 | Short interval expired since the last phase change |
| long_exp_o | output | 1 | Long interval expired since the last phase change |

## Verification
The lamps decode the phase register directly. A wrong next-state choice therefore shows on both lamp vectors and on the phase code in the very cycle after the faulty edge. A timer that fails to restart, or that counts to the wrong limit, does not change the lamps at once. It shows as a phase that is one or more cycles too short or too long, and it is caught when that phase ends. The flags are also checked for their first-high cycle within a phase. Sensor decisions are checked at the boundaries that matter: a vehicle arriving after the main road's limit, a vehicle leaving during side green, and a vehicle held through the whole side green.

// File: rtl/sig_pkg.sv
package sig_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_e;

  localparam int LAMP_W = 3;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 3'b001;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_RED = 3'b100;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          saturated;

  assign saturated = (cnt_q == LONG_V);
  assign cnt_en    = restart_i | ~saturated;

  always_comb begin
    if (restart_i) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign short_done_o = (cnt_q >= SHORT_V);
  assign long_done_o  = saturated;
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import sig_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_i,
  input  logic   short_done_i,
  input  logic   long_done_i,
  output phase_e phase_o,
  output logic   restart_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_MAIN_GO:   if (car_i && long_done_i)   state_d = PH_MAIN_WARN;
      PH_MAIN_WARN: if (short_done_i)           state_d = PH_SIDE_GO;
      PH_SIDE_GO:   if (!car_i || long_done_i)  state_d = PH_SIDE_WARN;
      PH_SIDE_WARN: if (short_done_i)           state_d = PH_MAIN_GO;
      default:                                  state_d = PH_MAIN_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_MAIN_GO;
    else        state_q <= state_d;
  end

  assign restart_o = (state_d != state_q);
  assign phase_o   = state_q;
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import sig_pkg::*;
(
  input  phase_e            phase_i,
  output logic [LAMP_W-1:0] main_o,
  output logic [LAMP_W-1:0] side_o
);
  always_comb begin
    main_o = LAMP_RED;
    side_o = LAMP_RED;
    unique case (phase_i)
      PH_MAIN_GO:   main_o = LAMP_GRN;
      PH_MAIN_WARN: main_o = LAMP_YEL;
      PH_SIDE_GO:   side_o = LAMP_GRN;
      PH_SIDE_WARN: side_o = LAMP_YEL;
      default: begin
        main_o = LAMP_RED;
        side_o = LAMP_RED;
      end
    endcase
  end
endmodule

// File: rtl/road_signal_ctrl.sv
module road_signal_ctrl
  import sig_pkg::*;
#(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_i,
  output logic [1:0] phase_o,
  output logic [2:0] main_lamp_o,
  output logic [2:0] side_lamp_o,
  output logic       short_exp_o,
  output logic       long_exp_o
);
  logic   rst_n_int;
  logic   restart;
  logic   short_done, long_done;
  phase_e phase;

  rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .restart_i    (restart),
    .short_done_o (short_done),
    .long_done_o  (long_done)
  );

  phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .car_i        (car_i),
    .short_done_i (short_done),
    .long_done_i  (long_done),
    .phase_o      (phase),
    .restart_o    (restart)
  );

  lamp_decode u_lamps (
    .phase_i (phase),
    .main_o  (main_lamp_o),
    .side_o  (side_lamp_o)
  );

  assign phase_o     = phase;
  assign short_exp_o = short_done;
  assign long_exp_o  = long_done;
endmodule

// File: rtl/road_signal_ctrl_chk.sv
module road_signal_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       car_i,
  input logic [1:0] phase_o,
  input logic [2:0] main_lamp_o,
  input logic [2:0] side_lamp_o,
  input logic       short_exp_o,
  input logic       long_exp_o
);
  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(main_lamp_o) && $onehot(side_lamp_o));                                  // R2
  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    main_lamp_o[2] || side_lamp_o[2]);                                               // R11
  AST_MAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && !car_i) |=> phase_o == 2'd0);                                // R3
  AST_MAIN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && !long_exp_o) |=> phase_o == 2'd0);                           // R4
  AST_MAIN_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && car_i && long_exp_o) |=> phase_o == 2'd1);                   // R5
  AST_MWARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && !short_exp_o) |=> phase_o == 2'd1);                          // R6
  AST_MWARN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && short_exp_o) |=> phase_o == 2'd2);                           // R6
  AST_SIDE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2 && !car_i) |=> phase_o == 2'd3);                                // R7
  AST_SIDE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2 && long_exp_o) |=> phase_o == 2'd3);                            // R8
  AST_SWARN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && short_exp_o) |=> phase_o == 2'd0);                           // R9
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (!short_exp_o && !long_exp_o));                  // R10
  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    long_exp_o |-> short_exp_o);                                                     // R10
endmodule

bind road_signal_ctrl road_signal_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .car_i       (car_i),
  .phase_o     (phase_o),
  .main_lamp_o (main_lamp_o),
  .side_lamp_o (side_lamp_o),
  .short_exp_o (short_exp_o),
  .long_exp_o  (long_exp_o)
);

// File: tb/road_signal_ctrl_bench.sv
module road_signal_ctrl_bench;
  localparam int SHORT = 3;
  localparam int LONG  = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       car_i;
  logic [1:0] phase_o;
  logic [2:0] main_lamp_o, side_lamp_o;
  logic       short_exp_o, long_exp_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  road_signal_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) u_road_signal_ctrl (
    .clk(clk), .rst_n(rst_n), .car_i(car_i), .phase_o(phase_o),
    .main_lamp_o(main_lamp_o), .side_lamp_o(side_lamp_o),
    .short_exp_o(short_exp_o), .long_exp_o(long_exp_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2 expected lamps per phase
  task automatic check_lamps(input string req, input logic [1:0] ph);
    logic [2:0] em, es;
    case (ph)
      2'd0: begin em = 3'b001; es = 3'b100; end
      2'd1: begin em = 3'b010; es = 3'b100; end
      2'd2: begin em = 3'b100; es = 3'b001; end
      default: begin em = 3'b100; es = 3'b010; end
    endcase
    check(req, int'(phase_o), int'(ph));
    check(req, int'(main_lamp_o), int'(em));
    check(req, int'(side_lamp_o), int'(es));
  endtask

  // called at the first cycle of phase p; returns at the first cycle of the next phase
  task automatic measure(input logic [1:0] p, output int n, output int s_idx, output int l_idx);
    n = 0; s_idx = 0; l_idx = 0;
    while (phase_o == p) begin
      n++;
      if (short_exp_o && s_idx == 0) s_idx = n;
      if (long_exp_o && l_idx == 0)  l_idx = n;
      @(negedge clk);
    end
  endtask

  // R11 and R2 invariant every cycle
  always @(negedge clk) begin
    cyc++;
    n_chk++;
    if ((!main_lamp_o[2] && !side_lamp_o[2]) || !$onehot(main_lamp_o) || !$onehot(side_lamp_o)) begin
      n_fail++;
      $display("FAIL R11: actual main %b side %b expected one lamp each, one road red",
               main_lamp_o, side_lamp_o);
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic t_reset_idle();
    rst_n = 1'b0; car_i = 1'b0;
    repeat (3) @(negedge clk);
    check_lamps("R1", 2'd0);
    check("R1 short", int'(short_exp_o), 0);
    check("R1 long", int'(long_exp_o), 0);
    rst_n = 1'b1;
    repeat (3 * LONG + 5) @(negedge clk);
    check("R3 idle phase", int'(phase_o), 0);
    check("R10 long stays high", int'(long_exp_o), 1);
  endtask

  task automatic t_late_car();
    int n, s, l;
    car_i = 1'b1;
    @(negedge clk);
    check_lamps("R5 R2 main yellow", 2'd1);
    check("R10 flags clear", int'(short_exp_o) + int'(long_exp_o), 0);
    measure(2'd1, n, s, l);
    check("R6 yellow length", n, SHORT + 1);
    check_lamps("R2 side green", 2'd2);
    measure(2'd2, n, s, l);
    check("R8 side green limit", n, LONG + 1);
    check_lamps("R2 side yellow", 2'd3);
    car_i = 1'b1;  // held so the next main green starts with a car waiting
    measure(2'd3, n, s, l);
    check("R9 side yellow length", n, SHORT + 1);
  endtask

  task automatic t_car_waiting();
    int n, s, l;
    check_lamps("R9 back to main green", 2'd0);
    measure(2'd0, n, s, l);
    check("R4 main minimum", n, LONG + 1);
    check("R10 short first cycle", s, SHORT + 1);
    check("R10 long first cycle", l, LONG + 1);
    measure(2'd1, n, s, l);
    check("R6 yellow length again", n, SHORT + 1);
    @(negedge clk);
    check("R7 still side green", int'(phase_o), 2);
    car_i = 1'b0;
    @(negedge clk);
    check("R7 car left", int'(phase_o), 3);
    measure(2'd3, n, s, l);
    check("R9 yellow ignores sensor", n, SHORT + 1);
    repeat (2 * LONG) @(negedge clk);
    check("R3 idle after cycle", int'(phase_o), 0);
  endtask

  initial begin
    t_reset_idle();
    t_late_car();
    t_car_waiting();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule